// File: doc/BRIEF.md
# NAND Flash Controller Host Register Front End

This block is the software-facing register file of a NAND flash controller with an 8-bit data path. Command bytes, address bytes, data bytes and read requests are written to separate registers. Each one becomes a tagged entry in a small in-order write buffer. A back end takes the entries one at a time and presents each one, with its tag, to the flash pin engine. Here that back end is a stub whose per-entry duration comes from the strobe delay fields of the control register.

A data read is a two-step handshake. Software writes any value to the read-request register and waits for the read-ready interrupt flag. It then fetches the byte from the read-data register and clears the flag by writing 1 to it. Events are collected in a sticky interrupt status register that software clears by writing 1s. A mask register selects which of those events drive the interrupt line. A self-clearing bit restarts the ECC generator.

Top module: `nfc_host_regs`

## Requirements
- R1: After reset, CTRL (offset 0) reads 0x0000, STATUS (offset 1) reads 0x0011, IRQ_STAT (offset 2) and IRQ_MASK (offset 3) read 0, `irq` is low and the ECC restart register (offset 9) reads 0.
- R2: CTRL keeps bits [9:0] of a write and reads 0 in bits [15:10]. The fields are: write strobe delay [3:0], read strobe delay [7:4], width select [8], page select [9] (1 = 512-byte page).
- R3: Writes to offsets 4 (command), 5 (address), 6 (data write) and 7 (read request) each queue one entry. The entry's byte is wdata[7:0] and its tag is 0, 1, 2 or 3 respectively. The back end presents the entries on `nand_op_*` in exactly the order they were written.
- R4: The buffer holds BUF_DEPTH (4) entries. STATUS bit1 is set while it is full. A queue write made while the buffer is full is dropped and sets IRQ_STAT bit1.
- R5: The back end takes an entry as soon as it is idle and the buffer is not empty. It holds each entry for D+1 cycles. D is the read strobe delay for read requests and the write strobe delay for all other entries. STATUS bit0 (idle) reads 1 only when the buffer is empty and no entry is in progress.
- R6: When a read request completes, IRQ_STAT bit3 is set and READ_DATA (offset 8, bits [7:0]) holds the returned byte. In this model the returned byte is the last data-write byte that the back end has taken. STATUS bit3 is set while a read request is queued or in progress.
- R7: STATUS bit2 is set while a data write is queued or in progress. IRQ_STAT bit4 is set when a data write completes.
- R8: IRQ_STAT bit0 is set when STATUS bit0 rises. IRQ_STAT bit2 is set when the buffer stops being full.
- R9: Writing IRQ_STAT clears exactly the bits written as 1, starting the next cycle. Bits written as 0 keep their value. An event in the same cycle as the write wins over the clear.
- R10: `irq` is high exactly when some IRQ_STAT bit is set whose IRQ_MASK bit is also set.
- R11: Writing 1 to bit0 of offset 9 makes that bit read 1 and holds `ecc_clear` high for ECC_RST_CYC cycles; then both clear by themselves. Writing 0 has no effect.
- R12: STATUS bit4 is set exactly when the write buffer holds no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register (combinational) |
| irq | output | 1 | Masked interrupt request |
| ecc_clear | output | 1 | High while the ECC generator restarts |
| nand_op_valid | output | 1 | One-cycle pulse when the back end takes an entry |
| nand_op_tag | output | 2 | Tag of the entry in progress |
| nand_op_byte | output | 8 | Byte of the entry in progress |

## Verification
A register write made at clock edge P is visible on `bus_rdata` at the falling edge that follows P. This covers the control, mask, W1C and overflow results. Starting from an idle controller, a queued entry with delay D brings the idle bit back, and sets the read-ready or write-done flag, at the falling edge D+2 cycles after P. The ECC restart bit reads 1 on exactly ECC_RST_CYC falling edges. The bench samples only at falling edges and counts those edges against these figures. Where the exact cycle is not the subject of the check, it polls with a timeout.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
    localparam int REG_AW = 4;
    localparam int BUS_W  = 16;
    localparam int CTRL_W = 10;
    localparam int IST_W  = 5;

    typedef enum logic [1:0] {
        TAG_CMD   = 2'd0,
        TAG_ADDR  = 2'd1,
        TAG_DWR   = 2'd2,
        TAG_RDREQ = 2'd3
    } op_tag_e;

    typedef struct packed {
        op_tag_e    tag;
        logic [7:0] dat;
    } op_ent_t;

    typedef struct packed {
        logic       page512;
        logic       wide;
        logic [3:0] rd_dly;
        logic [3:0] wr_dly;
    } ctrl_t;

    localparam logic [REG_AW-1:0] OFS_CTRL  = 4'd0;
    localparam logic [REG_AW-1:0] OFS_STAT  = 4'd1;
    localparam logic [REG_AW-1:0] OFS_ISTAT = 4'd2;
    localparam logic [REG_AW-1:0] OFS_MASK  = 4'd3;
    localparam logic [REG_AW-1:0] OFS_CMD   = 4'd4;
    localparam logic [REG_AW-1:0] OFS_ADR   = 4'd5;
    localparam logic [REG_AW-1:0] OFS_DWR   = 4'd6;
    localparam logic [REG_AW-1:0] OFS_RDREQ = 4'd7;
    localparam logic [REG_AW-1:0] OFS_RDAT  = 4'd8;
    localparam logic [REG_AW-1:0] OFS_ECC   = 4'd9;

    localparam int IS_IDLE = 0;
    localparam int IS_OVF  = 1;
    localparam int IS_EDGE = 2;
    localparam int IS_RRDY = 3;
    localparam int IS_WDON = 4;

    function automatic logic [IST_W-1:0] w1c_update(input logic [IST_W-1:0] cur,
                                                    input logic [IST_W-1:0] set,
                                                    input logic [IST_W-1:0] clr);
        return (cur & ~clr) | set;
    endfunction

    function automatic op_tag_e tag_of(input logic [REG_AW-1:0] ofs);
        case (ofs)
            OFS_ADR:   return TAG_ADDR;
            OFS_DWR:   return TAG_DWR;
            OFS_RDREQ: return TAG_RDREQ;
            default:   return TAG_CMD;
        endcase
    endfunction
endpackage

// File: rtl/nfc_wbuf.sv
module nfc_wbuf import nfc_pkg::*; #(
    parameter int DEPTH = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    push,
    input  op_ent_t din,
    input  logic    pop,
    output op_ent_t head,
    output logic    full,
    output logic    empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    op_ent_t            mem [DEPTH];
    logic [PTR_W-1:0]   wptr, rptr;
    logic [CNT_W-1:0]   count;
    logic               do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                mem[wptr] <= din;
                wptr      <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            end
            if (do_pop)
                rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    p_count_bound_r4: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    p_full_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> full);
endmodule

// File: rtl/nfc_stub.sv
module nfc_stub import nfc_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] dly_wr,
    input  logic [3:0] dly_rd,
    input  logic       avail,
    input  op_ent_t    head,
    output logic       pop,
    output logic       busy,
    output logic       done,
    output op_ent_t    cur,
    output logic       op_valid,
    output logic [7:0] rd_byte
);
    logic [3:0] cnt;
    logic [7:0] loop_q;

    assign pop     = !busy && avail;
    assign done    = busy && (cnt == '0);
    assign rd_byte = loop_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cnt      <= '0;
            op_valid <= 1'b0;
            cur      <= '{tag: TAG_CMD, dat: 8'h00};
            loop_q   <= '0;
        end else begin
            op_valid <= 1'b0;
            if (busy) begin
                if (cnt == '0) busy <= 1'b0;
                else           cnt  <= cnt - 1'b1;
            end else if (avail) begin
                busy     <= 1'b1;
                op_valid <= 1'b1;
                cur      <= head;
                cnt      <= (head.tag == TAG_RDREQ) ? dly_rd : dly_wr;
                if (head.tag == TAG_DWR) loop_q <= head.dat;
            end
        end
    end
endmodule

// File: rtl/nfc_ecc_rst.sv
module nfc_ecc_rst #(
    parameter int CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYC + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= CW'(CYC - 1);
        end
    end
endmodule

// File: rtl/nfc_host_regs.sv
module nfc_host_regs import nfc_pkg::*; #(
    parameter int BUF_DEPTH   = 4,
    parameter int ECC_RST_CYC = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        irq,
    output logic        ecc_clear,
    output logic        nand_op_valid,
    output logic [1:0]  nand_op_tag,
    output logic [7:0]  nand_op_byte
);
    localparam int PND_W = $clog2(BUF_DEPTH + 2);

    ctrl_t             ctrl_q;
    logic [IST_W-1:0]  istat_q, mask_q, set_ev;
    logic [7:0]        rdat_q;
    logic [PND_W-1:0]  wr_pend, rd_pend;
    logic              idle, idle_q, full_q;
    logic              push_req, buf_full, buf_empty, pop, busy, done, op_valid;
    logic              wr_istat, ecc_busy, rd_done, wd_done, push_ok;
    op_ent_t           push_ent, head, cur;
    logic [7:0]        rd_byte;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata[15:CTRL_W];

    assign push_req = bus_wr && (bus_addr == OFS_CMD || bus_addr == OFS_ADR ||
                                 bus_addr == OFS_DWR || bus_addr == OFS_RDREQ);
    assign push_ok  = push_req && !buf_full;
    assign push_ent = '{tag: tag_of(bus_addr), dat: bus_wdata[7:0]};
    assign wr_istat = bus_wr && bus_addr == OFS_ISTAT;

    nfc_wbuf #(.DEPTH(BUF_DEPTH)) u_wbuf (
        .clk(clk), .rst(rst), .push(push_req), .din(push_ent), .pop(pop),
        .head(head), .full(buf_full), .empty(buf_empty)
    );

    nfc_stub u_stub (
        .clk(clk), .rst(rst), .dly_wr(ctrl_q.wr_dly), .dly_rd(ctrl_q.rd_dly),
        .avail(!buf_empty), .head(head), .pop(pop), .busy(busy), .done(done),
        .cur(cur), .op_valid(op_valid), .rd_byte(rd_byte)
    );

    nfc_ecc_rst #(.CYC(ECC_RST_CYC)) u_ecc (
        .clk(clk), .rst(rst),
        .start(bus_wr && bus_addr == OFS_ECC && bus_wdata[0]),
        .busy(ecc_busy)
    );

    assign rd_done = done && cur.tag == TAG_RDREQ;
    assign wd_done = done && cur.tag == TAG_DWR;
    assign idle    = buf_empty && !busy;

    always_comb begin
        set_ev          = '0;
        set_ev[IS_IDLE] = idle && !idle_q;
        set_ev[IS_OVF]  = push_req && buf_full;
        set_ev[IS_EDGE] = full_q && !buf_full;
        set_ev[IS_RRDY] = rd_done;
        set_ev[IS_WDON] = wd_done;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            istat_q <= '0;
            mask_q  <= '0;
            rdat_q  <= '0;
            wr_pend <= '0;
            rd_pend <= '0;
            idle_q  <= 1'b1;
            full_q  <= 1'b0;
        end else begin
            idle_q  <= idle;
            full_q  <= buf_full;
            istat_q <= w1c_update(istat_q, set_ev,
                                  wr_istat ? bus_wdata[IST_W-1:0] : '0);
            if (bus_wr && bus_addr == OFS_CTRL) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (bus_wr && bus_addr == OFS_MASK) mask_q <= bus_wdata[IST_W-1:0];
            if (rd_done) rdat_q <= rd_byte;
            wr_pend <= wr_pend + PND_W'(push_ok && bus_addr == OFS_DWR) - PND_W'(wd_done);
            rd_pend <= rd_pend + PND_W'(push_ok && bus_addr == OFS_RDREQ) - PND_W'(rd_done);
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL:  bus_rdata[CTRL_W-1:0] = ctrl_q;
            OFS_STAT:  bus_rdata[4:0] = {buf_empty, rd_pend != '0, wr_pend != '0,
                                         buf_full, idle};
            OFS_ISTAT: bus_rdata[IST_W-1:0] = istat_q;
            OFS_MASK:  bus_rdata[IST_W-1:0] = mask_q;
            OFS_RDAT:  bus_rdata[7:0] = rdat_q;
            OFS_ECC:   bus_rdata[0] = ecc_busy;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq           = |(istat_q & mask_q);
    assign ecc_clear     = ecc_busy;
    assign nand_op_valid = op_valid;
    assign nand_op_tag   = cur.tag;
    assign nand_op_byte  = cur.dat;

    p_ovf_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (push_req && buf_full) |=> istat_q[IS_OVF]);
    p_w1c_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_istat && set_ev == '0) |=> ((istat_q & $past(bus_wdata[IST_W-1:0])) == '0));
    p_ecc_start_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(ecc_busy) |-> $past(bus_wr && bus_addr == OFS_ECC && bus_wdata[0]));
    p_rd_pend_r6: assert property (@(posedge clk) disable iff (rst)
        rd_done |-> rd_pend != '0);
    p_pop_idle_r5: assert property (@(posedge clk) disable iff (rst)
        op_valid |-> $past(!busy));
endmodule

// File: tb/nfc_host_regs_bench.sv
module nfc_host_regs_bench;
    localparam int CLK_P = 10;
    localparam int ECYC  = 8;

    logic        clk = 1'b0, rst = 1'b1, bw = 1'b0;
    logic [3:0]  ba = '0;
    logic [15:0] bd = '0, rdv;
    logic        irq, ecc_clear, op_v;
    logic [1:0]  op_t;
    logic [7:0]  op_b;
    int checks = 0, errors = 0;
    logic [9:0] exp_log [512];
    logic [9:0] got_log [512];
    int en = 0, gn = 0;

    always #(CLK_P/2) clk = ~clk;

    nfc_host_regs #(.BUF_DEPTH(4), .ECC_RST_CYC(ECYC)) u_nfc_host_regs (
        .clk(clk), .rst(rst), .bus_wr(bw), .bus_addr(ba), .bus_wdata(bd),
        .bus_rdata(rdv), .irq(irq), .ecc_clear(ecc_clear),
        .nand_op_valid(op_v), .nand_op_tag(op_t), .nand_op_byte(op_b));

    always @(negedge clk)
        if (!rst && op_v && gn < 512) begin
            got_log[gn] = {op_t, op_b};
            gn++;
        end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        bw = 1'b1; ba = a; bd = d;
        @(negedge clk);
        bw = 1'b0;
    endtask

    task automatic q(input logic [3:0] a, input logic [7:0] b);
        exp_log[en] = {a - 4'd4 == 4'd0 ? 2'd0 : a == 4'd5 ? 2'd1 : a == 4'd6 ? 2'd2 : 2'd3, b};
        en++;
        wr(a, {8'h00, b});
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        ba = a; #1; d = rdv;
    endtask

    task automatic wait_bit(input logic [3:0] a, input int b, input string req);
        logic [15:0] v;
        int n;
        n = 0;
        rd(a, v);
        while (!v[b] && n < 200) begin
            @(negedge clk); n++; rd(a, v);
        end
        if (n >= 200) begin
            checks++; errors++;
            $display("FAIL %s timeout actual=0 expected=1", req);
        end
    endtask

    function automatic logic [15:0] ctrl_rb(input logic [15:0] w);
        return w & 16'h03FF;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v, r;
        logic [7:0]  b;
        logic [4:0]  m;
        int n;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd(4'd0, v); chk("R1 ctrl", v, 16'h0000);
        rd(4'd1, v); chk("R1 status", v, 16'h0011);
        rd(4'd2, v); chk("R1 istat", v, 16'h0000);
        rd(4'd3, v); chk("R1 mask", v, 16'h0000);
        rd(4'd9, v); chk("R1 ecc", v, 16'h0000);
        chk("R1 irq", irq, 1'b0);
        // R2 control fields
        wr(4'd0, 16'hFFFF); rd(4'd0, v); chk("R2 ctrl readback", v, 16'h03FF);
        // R5 write delay timing, d = 3
        wr(4'd0, 16'h0003);
        q(4'd4, 8'h70);
        n = 0; rd(4'd1, v);
        while (!v[0] && n < 100) begin n++; @(negedge clk); rd(4'd1, v); end
        chk("R5 cmd duration", n, 5);
        // R5/R6 read delay timing, rd = 5, wr = 0 ; R3 address entry
        wr(4'd0, 16'h0050);
        q(4'd5, 8'h3C);
        wait_bit(4'd1, 0, "R5 idle");
        wr(4'd2, 16'hFFFF);
        q(4'd6, 8'hA7);
        wait_bit(4'd1, 0, "R7 idle");
        q(4'd7, 8'h00);
        n = 0; rd(4'd2, v);
        while (!v[3] && n < 100) begin n++; @(negedge clk); rd(4'd2, v); end
        chk("R5 read duration", n, 7);
        rd(4'd8, v); chk("R6 read data", v, 16'h00A7);
        rd(4'd2, v); chk("R7 write done flag", v[4], 1'b1);
        // R9 partial clear
        @(negedge clk);
        rd(4'd2, v); chk("R9 before", v[4:3], 2'b11);
        wr(4'd2, 16'h0008); rd(4'd2, v); chk("R9 clear bit3", v[4:3], 2'b10);
        wr(4'd2, 16'h0000); rd(4'd2, v); chk("R9 zero write", v[4:3], 2'b10);
        wr(4'd2, 16'hFFFF); rd(4'd2, v); chk("R9 clear all", v, 16'h0000);
        // R4 overflow and R12 / R8 edge
        wr(4'd0, 16'h000F);
        q(4'd4, 8'h11); q(4'd5, 8'h22); q(4'd5, 8'h33); q(4'd6, 8'h44); q(4'd5, 8'h55);
        rd(4'd1, v); chk("R4 full", v[1], 1'b1);
        chk("R12 not empty", v[4], 1'b0);
        chk("R7 write pending", v[2], 1'b1);
        rd(4'd2, v); chk("R4 no ovf yet", v[1], 1'b0);
        wr(4'd4, 16'h0099);
        rd(4'd2, v); chk("R4 ovf flag", v[1], 1'b1);
        wr(4'd0, 16'h0000);
        wait_bit(4'd1, 0, "R4 drain");
        rd(4'd2, v); chk("R8 edge flag", v[2], 1'b1);
        rd(4'd1, v); chk("R12 empty", v, 16'h0011);
        // R11 ECC restart
        wr(4'd9, 16'h0000); rd(4'd9, v); chk("R11 zero write", v, 16'h0000);
        wr(4'd9, 16'h0001);
        n = 0; rd(4'd9, v);
        while (v[0] && n < 100) begin
            chk("R11 ecc_clear", ecc_clear, 1'b1);
            n++; @(negedge clk); rd(4'd9, v);
        end
        chk("R11 duration", n, ECYC);
        chk("R11 ecc_clear low", ecc_clear, 1'b0);
        // R6 read pending while queued
        wr(4'd0, 16'h00F0);
        q(4'd7, 8'h00);
        rd(4'd1, v); chk("R6 read pending", v[3], 1'b1);
        wait_bit(4'd1, 0, "R6 idle");
        rd(4'd1, v); chk("R6 pending cleared", v[3], 1'b0);
        @(negedge clk);
        wr(4'd2, 16'hFFFF);
        // random rounds: R2 R6 R7 R8 R10
        for (int i = 0; i < 40; i++) begin
            r = 16'($urandom) & 16'hFF33;
            b = 8'($urandom);
            m = 5'($urandom);
            wr(4'd0, r); rd(4'd0, v); chk("R2 random ctrl", v, ctrl_rb(r));
            wr(4'd2, 16'h001F); rd(4'd2, v); chk("R9 cleared", v, 16'h0000);
            chk("R10 irq off", irq, 1'b0);
            q(4'd6, b); q(4'd7, 8'h00);
            wait_bit(4'd2, 3, "R6 ready");
            wait_bit(4'd1, 0, "R5 idle");
            @(negedge clk);
            rd(4'd8, v); chk("R6 random data", v, {8'h00, b});
            rd(4'd2, v); chk("R8 istat pattern", v, 16'h0019);
            wr(4'd3, {11'h000, m});
            chk("R10 irq", irq, |(m & 5'h19));
        end
        wr(4'd3, 16'h0000);
        chk("R10 masked", irq, 1'b0);
        // R3 order
        chk("R3 op count", gn, en);
        for (int k = 0; k < en && k < 512; k++) chk("R3 op entry", got_log[k], exp_log[k]);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule